// File: doc/BRIEF.md
# Internal Composite Sync Generator

This block produces the video timing used to overlay characters on a television picture when the overlay runs without an incoming picture, or alongside one. It is clocked at twice or four times the colour subcarrier frequency. From that clock it derives line and field counters. It then produces a horizontal sync, a vertical sync, a composite sync that includes the equalizing and broad serration pulses, a blanking gate, a colour-burst gate and a field flag. It supports the NTSC and PAL-M line rates. The field structure can be interlaced (an odd number of half-lines, so each field starts half a line later than the last) or non-interlaced (a whole number of lines).

Every clock, the block also emits a 4-bit level code. A downstream digital-to-analog stage turns that code into the composite output voltage: sync tip, pedestal, burst low or high, background low or high, one of two trimming levels, character level, or pass-through of external video. A mode input picks internal timing or external sync. In external mode, the composite sync output follows a synchronised copy of the external sync input. A detector watches the external sync edges. It raises a presence flag and pulses a change flag whenever presence starts or stops.

Top module: `sync_timing_gen`

## Requirements
- R1: The line length in clocks is `LINE_NTSC_4X` (NTSC, `palm_sel`=0) or `LINE_PALM_4X` (PAL-M) when `fs4_sel`=1. When `fs4_sel`=0 it is that value halved. If the value is odd, lines alternate between floor(L/2) and floor(L/2)+1 clocks, starting with the shorter line after reset. `hsync_n` is low for the first HS clocks of every line, where HS is `HS_4X` at 4x and `HS_4X/2` at 2x. All other widths scale the same way.
- R2: A field is 2*`FIELD_LINES`+1 half-lines when `nonint`=0 and 2*`FIELD_LINES`+2 half-lines when `nonint`=1. A half-line is the first floor(L/2) clocks of a line or the rest of it. `field` toggles at each field start.
- R3: Half-lines 0-5 and 12-17 of a field each start with an equalizing pulse: `csync_n` is low for EQ clocks. Half-lines 6-11 each start with a broad pulse: `csync_n` is low for floor(L/2)-HS clocks. `vsync_n` is low exactly during half-lines 6-11.
- R4: Outside half-lines 0-17, `csync_n` is low only during the first HS clocks of a line. It stays high at the start of a second half.
- R5: `blank` is high during half-lines 0 to 2*`VBL_LINES`-1 and during the first BLANK clocks of every line. `burst_gate` is high on clocks BURST_ST to BURST_ST+BURST_LEN-1 of a line, but only outside half-lines 0-17 and only in the first half of the line.
- R6: With `int_sync`=1, `level` follows this priority. Sync low gives 0. The burst gate gives 3 when the carrier phase is 1 and 2 otherwise; the phase is bit 1 of the line position at 4x and bit 0 at 2x. Blank gives 1. `char_dot` gives 8. `trim_dot` gives 7 if `trim_sel`=1 and 6 otherwise. Background gives 5 or 4. Anything else gives 1.
- R7: The background levels appear only with `int_sync`=1 and `bg_en`=1. Blue uses the carrier phase directly (phase 1 gives 5), green uses it inverted. PAL-M is always blue, whatever `bg_blue` says.
- R8: With `int_sync`=0, `csync_n` equals `ext_sync_n` delayed by two clocks. `level` is 9 (pass-through) while blanked, otherwise 8 for `char_dot`, otherwise 7 or 6 for `trim_dot`, otherwise 9. `hsync_n`, `vsync_n`, `blank` and `field` keep the internal timing.
- R9: With `det_en`=1, `ext_present` rises two clocks after a falling edge of `ext_sync_n` is seen on the synchronised input. It falls after `MISS_LIMIT` whole line periods pass with no falling edge. With `det_en`=0 it is forced low on the next clock.
- R10: `ext_change` is high for exactly one clock after each rise or fall of `ext_present`.
- R11: After reset the position and half-line count are zero: `hsync_n`=0, `csync_n`=0, `vsync_n`=1, `blank`=1, `field`=0, `ext_present`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x or 4x subcarrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs4_sel | input | 1 | 1: clock is 4x subcarrier, 0: 2x |
| palm_sel | input | 1 | 1: PAL-M timing, 0: NTSC |
| nonint | input | 1 | 1: non-interlaced fields |
| int_sync | input | 1 | 1: internal sync, 0: external |
| bg_en | input | 1 | Show the background screen (internal mode) |
| bg_blue | input | 1 | Background colour: 1 blue, 0 green |
| det_en | input | 1 | Enable external sync detection |
| ext_sync_n | input | 1 | External composite or horizontal sync, active low |
| char_dot | input | 1 | Character dot active this clock |
| trim_dot | input | 1 | Character border dot active this clock |
| trim_sel | input | 1 | Trimming level select |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Blanking gate |
| burst_gate | output | 1 | Colour burst gate |
| field | output | 1 | Field flag |
| level | output | 4 | Output level code |
| ext_present | output | 1 | External sync present |
| ext_change | output | 1 | One-clock pulse on presence change |

## Verification
The assertions check three things on every cycle. The line position never reaches the current line length. The field flag flips at every field wrap. The vertical sync window always coincides with a low composite sync at the start of each half-line. They also check that the presence flag only rises after a seen edge and only falls when detection is disabled or a line period expires, and that the burst gate never overlaps sync. The exact pulse widths, the alternating PAL-M half-rate line lengths, the half-line shift between interlaced fields and the level-code priority can only be shown by the bench. It sweeps every combination of clock rate, standard and field mode over three fields and compares each output against an arithmetic model. The eight-line absence timeout and the pass-through of external sync are covered by a dedicated external-mode scenario.

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int LINE_NTSC_4X = 910,
  parameter int LINE_PALM_4X = 909,
  parameter int FIELD_LINES  = 262,
  parameter int VBL_LINES    = 20,
  parameter int HS_4X        = 68,
  parameter int EQ_4X        = 34,
  parameter int BLANK_4X     = 156,
  parameter int BURST_ST_4X  = 76,
  parameter int BURST_LEN_4X = 36,
  parameter int MISS_LIMIT   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs4_sel,
  input  logic       palm_sel,
  input  logic       nonint,
  input  logic       int_sync,
  input  logic       bg_en,
  input  logic       bg_blue,
  input  logic       det_en,
  input  logic       ext_sync_n,
  input  logic       char_dot,
  input  logic       trim_dot,
  input  logic       trim_sel,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       csync_n,
  output logic       blank,
  output logic       burst_gate,
  output logic       field,
  output logic [3:0] level,
  output logic       ext_present,
  output logic       ext_change
);
  localparam int LMAX = (LINE_NTSC_4X > LINE_PALM_4X) ? LINE_NTSC_4X : LINE_PALM_4X;
  localparam int PW = $clog2(LMAX + 1);
  localparam int VW = $clog2(2 * FIELD_LINES + 3);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  localparam logic [3:0] LV_SYNC = 4'd0, LV_PED = 4'd1, LV_BST_LO = 4'd2, LV_BST_HI = 4'd3,
                         LV_BG_LO = 4'd4, LV_BG_HI = 4'd5, LV_TRIM0 = 4'd6, LV_TRIM1 = 4'd7,
                         LV_CHAR = 4'd8, LV_PASS = 4'd9;

  logic [PW-1:0] pos, l4, line_len, half_len, sub;
  logic [PW-1:0] hs_w, eq_w, blank_w, bst_w, blen_w;
  logic [VW-1:0] vh, fh;
  logic          line_par, second, line_end, half_end;

  assign l4       = palm_sel ? PW'(LINE_PALM_4X) : PW'(LINE_NTSC_4X);
  assign line_len = fs4_sel ? l4 : (l4 >> 1) + {{(PW-1){1'b0}}, l4[0] & line_par};
  assign half_len = line_len >> 1;
  assign second   = pos >= half_len;
  assign sub      = second ? pos - half_len : pos;
  assign line_end = pos == line_len - 1'b1;
  assign half_end = line_end || (pos == half_len - 1'b1);
  assign fh       = nonint ? VW'(2 * FIELD_LINES + 2) : VW'(2 * FIELD_LINES + 1);

  assign hs_w    = fs4_sel ? PW'(HS_4X)        : PW'(HS_4X / 2);
  assign eq_w    = fs4_sel ? PW'(EQ_4X)        : PW'(EQ_4X / 2);
  assign blank_w = fs4_sel ? PW'(BLANK_4X)     : PW'(BLANK_4X / 2);
  assign bst_w   = fs4_sel ? PW'(BURST_ST_4X)  : PW'(BURST_ST_4X / 2);
  assign blen_w  = fs4_sel ? PW'(BURST_LEN_4X) : PW'(BURST_LEN_4X / 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      line_par <= 1'b0;
      vh <= '0;
      field <= 1'b0;
    end else begin
      if (line_end) begin
        pos <= '0;
        line_par <= ~line_par;
      end else begin
        pos <= pos + 1'b1;
      end
      if (half_end) begin
        if (vh == fh - 1'b1) begin
          vh <= '0;
          field <= ~field;
        end else begin
          vh <= vh + 1'b1;
        end
      end
    end
  end

  logic eq_zone, ser_zone, sync_low, phase, blue;
  assign ser_zone = (vh >= VW'(6)) && (vh < VW'(12));
  assign eq_zone  = (vh < VW'(6)) || ((vh >= VW'(12)) && (vh < VW'(18)));
  assign sync_low = ser_zone ? (sub < half_len - hs_w) :
                    eq_zone  ? (sub < eq_w) : (!second && pos < hs_w);
  assign phase    = fs4_sel ? pos[1] : pos[0];
  assign blue     = palm_sel | bg_blue;

  assign hsync_n    = !(pos < hs_w);
  assign vsync_n    = !ser_zone;
  assign blank      = (vh < VW'(2 * VBL_LINES)) || (pos < blank_w);
  assign burst_gate = !eq_zone && !ser_zone && !second && (pos >= bst_w) && (pos < bst_w + blen_w);

  logic [2:0] ext_s;
  logic       ext_fall, present_d;
  logic [PW-1:0] gap;
  logic [MW-1:0] miss;
  assign ext_fall = ext_s[2] & ~ext_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s <= 3'b111;
      ext_present <= 1'b0;
      present_d <= 1'b0;
      gap <= '0;
      miss <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_sync_n};
      present_d <= ext_present;
      if (!det_en) begin
        ext_present <= 1'b0;
        gap <= '0;
        miss <= '0;
      end else if (ext_fall) begin
        ext_present <= 1'b1;
        gap <= '0;
        miss <= '0;
      end else if (gap == line_len - 1'b1) begin
        gap <= '0;
        if (miss == MW'(MISS_LIMIT - 1)) ext_present <= 1'b0;
        else miss <= miss + 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  assign ext_change = ext_present ^ present_d;
  assign csync_n = int_sync ? !sync_low : ext_s[1];

  always_comb begin
    if (!int_sync) begin
      if (blank)         level = LV_PASS;
      else if (char_dot) level = LV_CHAR;
      else if (trim_dot) level = trim_sel ? LV_TRIM1 : LV_TRIM0;
      else               level = LV_PASS;
    end else if (sync_low)   level = LV_SYNC;
    else if (burst_gate)     level = phase ? LV_BST_HI : LV_BST_LO;
    else if (blank)          level = LV_PED;
    else if (char_dot)       level = LV_CHAR;
    else if (trim_dot)       level = trim_sel ? LV_TRIM1 : LV_TRIM0;
    else if (bg_en)          level = (blue ? phase : !phase) ? LV_BG_HI : LV_BG_LO;
    else                     level = LV_PED;
  end

  p_pos_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n) pos < line_len);
  p_field_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && vh == fh - 1'b1) |=> (field != $past(field)));
  p_vsync_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sync && !vsync_n && sub == '0) |-> !csync_n);
  p_burst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sync && burst_gate) |-> csync_n);
  p_rise_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_present) |-> $past(ext_fall && det_en));
  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_present) |-> $past(!det_en || (gap == line_len - 1'b1)));
  p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !ext_present);
endmodule

// File: tb/sync_timing_gen_tb.sv
module sync_timing_gen_tb;
  localparam int LN = 30, LP = 29, FL = 12, VBL = 10;
  localparam int HS4 = 4, EQ4 = 2, BLK4 = 12, BST4 = 6, BLEN4 = 4, MISS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fs4_sel = 1'b1, palm_sel = 1'b0, nonint = 1'b0, int_sync = 1'b1;
  logic bg_en = 1'b1, bg_blue = 1'b1, det_en = 1'b0, ext_sync_n = 1'b1;
  logic char_dot = 1'b0, trim_dot = 1'b0, trim_sel = 1'b0;
  logic hsync_n, vsync_n, csync_n, blank, burst_gate, field, ext_present, ext_change;
  logic [3:0] level;

  sync_timing_gen #(.LINE_NTSC_4X(LN), .LINE_PALM_4X(LP), .FIELD_LINES(FL), .VBL_LINES(VBL),
    .HS_4X(HS4), .EQ_4X(EQ4), .BLANK_4X(BLK4), .BURST_ST_4X(BST4), .BURST_LEN_4X(BLEN4),
    .MISS_LIMIT(MISS)) u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, changes = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n && ext_change) changes++;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int e_hs, e_vs, e_cs, e_blank, e_burst, e_field, e_level, e_phase;

  task automatic model(int t);
    int l4, len0, len1, pair, q, r, line, pos, len, half, sec, sub, g, fh, vh;
    int hs, eq, blk, bst, blen, ser, eqz, slow, blue;
    l4 = palm_sel ? LP : LN;
    len0 = fs4_sel ? l4 : l4 / 2;
    len1 = fs4_sel ? l4 : l4 / 2 + l4 % 2;
    pair = len0 + len1; q = t / pair; r = t % pair;
    if (r < len0) begin line = 2 * q; pos = r; len = len0; end
    else begin line = 2 * q + 1; pos = r - len0; len = len1; end
    half = len / 2; sec = (pos >= half); sub = sec ? pos - half : pos;
    g = 2 * line + sec; fh = nonint ? 2 * FL + 2 : 2 * FL + 1;
    vh = g % fh; e_field = (g / fh) % 2;
    hs = fs4_sel ? HS4 : HS4 / 2; eq = fs4_sel ? EQ4 : EQ4 / 2;
    blk = fs4_sel ? BLK4 : BLK4 / 2; bst = fs4_sel ? BST4 : BST4 / 2;
    blen = fs4_sel ? BLEN4 : BLEN4 / 2;
    ser = (vh >= 6 && vh < 12); eqz = (vh < 6) || (vh >= 12 && vh < 18);
    slow = ser ? (sub < half - hs) : eqz ? (sub < eq) : (!sec && pos < hs);
    e_hs = !(pos < hs); e_vs = !ser; e_cs = !slow;
    e_blank = (vh < 2 * VBL) || (pos < blk);
    e_burst = !ser && !eqz && !sec && pos >= bst && pos < bst + blen;
    e_phase = fs4_sel ? (pos >> 1) & 1 : pos & 1;
    blue = palm_sel | bg_blue;
    if (!int_sync) e_level = e_blank ? 9 : char_dot ? 8 : trim_dot ? (trim_sel ? 7 : 6) : 9;
    else if (slow) e_level = 0;
    else if (e_burst) e_level = e_phase ? 3 : 2;
    else if (e_blank) e_level = 1;
    else if (char_dot) e_level = 8;
    else if (trim_dot) e_level = trim_sel ? 7 : 6;
    else if (bg_en) e_level = (blue ? e_phase : !e_phase) ? 5 : 4;
    else e_level = 1;
  endtask

  task automatic pat(int t);
    char_dot = (t % 7 == 3); trim_dot = (t % 5 == 1); trim_sel = (t % 3 == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); #1;
    check("R11", "hsync_n", hsync_n, 0); check("R11", "csync_n", csync_n, 0);
    check("R11", "vsync_n", vsync_n, 1); check("R11", "blank", blank, 1);
    check("R11", "field", field, 0); check("R11", "ext_present", ext_present, 0);

    for (int cfg = 0; cfg < 8; cfg++) begin
      int cycles;
      fs4_sel = cfg[0]; palm_sel = cfg[1]; nonint = cfg[2];
      bg_blue = cfg[0] ^ cfg[2]; int_sync = 1'b1; det_en = 1'b0;
      cycles = 3 * (2 * FL + 2) * (fs4_sel ? LN : LN / 2) / 2;
      do_reset();
      for (int t = 0; t < cycles; t++) begin
        pat(t); bg_en = (t / 97) % 2 == 0;
        #1; model(t);
        check("R1", "hsync_n", hsync_n, e_hs);
        check("R3", "vsync_n", vsync_n, e_vs);
        check("R4", "csync_n", csync_n, e_cs);
        check("R5", "blank", blank, e_blank);
        check("R5", "burst_gate", burst_gate, e_burst);
        check("R2", "field", field, e_field);
        check("R6_R7", "level", level, e_level);
        @(negedge clk);
      end
    end

    fs4_sel = 1; palm_sel = 0; nonint = 0; int_sync = 0; det_en = 1; bg_en = 1;
    ext_sync_n = 1; changes = 0;
    do_reset();
    begin
      logic h1, h2;
      h1 = 1; h2 = 1;
      for (int n = 0; n < 560; n++) begin
        ext_sync_n = !(n < 300 && n % 30 < 2);
        pat(n);
        #1; model(n);
        if (n >= 2) check("R8", "csync_n ext", csync_n, h2);
        check("R8", "level ext", level, e_level);
        check("R1_R8", "hsync_n ext mode", hsync_n, e_hs);
        if (n == 299) check("R9", "present after pulses", ext_present, 1);
        if (n == 270 + 238) check("R9", "present before timeout", ext_present, 1);
        if (n == 270 + 248) check("R9", "present after 8 lines", ext_present, 0);
        h2 = h1; h1 = ext_sync_n;
        @(negedge clk);
      end
    end
    check("R10", "change pulses rise+fall", changes, 2);
    ext_sync_n = 0; @(negedge clk); ext_sync_n = 1;
    repeat (5) @(negedge clk);
    #1 check("R9", "present after new edge", ext_present, 1);
    det_en = 0; @(negedge clk);
    #1 check("R9", "present with detection off", ext_present, 0);
    repeat (3) @(negedge clk);
    check("R10", "change pulses total", changes, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule